// File: doc/BRIEF.md
# Receiver Width Guard Sequencer

This block runs a receiver reset sequence through a small register access port (address, write data, read data, a one-cycle enable, a write strobe and a ready return). When a reset request arrives, it asserts the receiver reset and reads a configuration word. It then rewrites that word with the internal-width field forced to a fixed code and waits for the physical-layer reset-done indication. After that it writes the saved word back and pulses a completion output.

A new reset request may land while the forced code is sitting in the register. The next pass would then read the forced code, and a plain sequencer would restore the forced code and leave the receiver stuck in the wrong width. A protection flag prevents this. It stays set from the force write until the restore write is in flight. While it is set, a fresh read does not replace the saved original, so the word written back is always the one read before any forcing took place.

Top module: `rx_width_guard`

## Requirements
- R1: Each pass issues three accesses in this order, all to address `CFG_ADDR`: a read (`port_we`=0), a force write (`port_we`=1), then a restore write (`port_we`=1).
- R2: The force write data equals the word just read, with the bits selected by `FIELD_MASK` (default 16'h3800) replaced by the same bits of `FORCE_BITS` (default 16'h0800). All other bits are unchanged.
- R3: On a pass that is not interrupted, the restore write data equals the word returned by the read of that pass.
- R4: When a reset request interrupts a pass after its force write and before its restore write, the restore write of the later pass writes the word read before the first force, and not the forced word it reads back.
- R5: The protection flag is set after any cycle spent in the force-write, force-completion, reset-done wait or restore-write state. It is cleared after a cycle in the restore-completion state. The saved original is captured from read data only when the flag is clear. The flag and the saved original are 0 after reset.
- R6: `rx_reset` is high from the read access through the wait for `pma_done`. It is low once `pma_done` has been seen, and low while the block is idle.
- R7: `port_en` is high for exactly one cycle per access. No new access is issued before `port_rdy` answers the previous one, unless a new reset request restarts the sequence.
- R8: `seq_done` is high for exactly one cycle, in the cycle after `port_rdy` answers the restore write.
- R9: `reset_req` passes through a two-flop synchronizer. A rising edge restarts the sequence with a read at any point: the read enable appears in the third cycle after the request is first sampled.
- R10: While `rst` is high and after it is released, `port_en`, `port_we`, `rx_reset` and `seq_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-port clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_req | input | 1 | Asynchronous receiver reset request; a rising edge starts a pass |
| pma_done | input | 1 | Physical-layer reset-done indication |
| port_rdy | input | 1 | One-cycle answer to the current access |
| port_rdata | input | 16 | Read data, valid with `port_rdy` |
| port_addr | output | ADDR_W | Access address (always `CFG_ADDR`) |
| port_en | output | 1 | One-cycle access strobe |
| port_we | output | 1 | Write qualifier for `port_en` |
| port_wdata | output | 16 | Write data |
| rx_reset | output | 1 | Receiver reset |
| seq_done | output | 1 | One-cycle completion pulse |

## Verification
The critical collision is a synchronized restart edge landing at the same time as an outstanding access or a pending flag update. The bench raises a request exactly when the force write is issued, and again after it has completed. It does this on passes whose stored word carries different field codes. The port model applies the abandoned force write, so the next read returns the forced word. The bench judges the run on the final register contents and on the logged restore data, which must both equal the word held before the first pass.

// File: rtl/rxwg_pkg.sv
package rxwg_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD,
        S_WAIT_RD,
        S_WR_FORCE,
        S_WAIT_WR1,
        S_WAIT_PMA,
        S_WR_RESTORE,
        S_WAIT_WR2
    } seq_state_e;

    typedef struct packed {
        logic en;
        logic we;
        logic hold_rst;
    } port_ctl_t;

    // Port strobes and receiver reset level implied by each state.
    function automatic port_ctl_t ctl_for(seq_state_e s);
        port_ctl_t c;
        c = '0;
        case (s)
            S_RD:         begin c.en = 1'b1; c.hold_rst = 1'b1; end
            S_WAIT_RD:    c.hold_rst = 1'b1;
            S_WR_FORCE:   begin c.en = 1'b1; c.we = 1'b1; c.hold_rst = 1'b1; end
            S_WAIT_WR1:   c.hold_rst = 1'b1;
            S_WAIT_PMA:   c.hold_rst = 1'b1;
            S_WR_RESTORE: begin c.en = 1'b1; c.we = 1'b1; end
            default:      c = '0;
        endcase
        return c;
    endfunction

    // Replace the masked field of a word, keep all other bits.
    function automatic word_t merge_field(word_t w, word_t fbits, word_t mask);
        return (w & ~mask) | (fbits & mask);
    endfunction

    function automatic logic in_guard_span(seq_state_e s);
        return (s == S_WR_FORCE) || (s == S_WAIT_WR1) ||
               (s == S_WAIT_PMA) || (s == S_WR_RESTORE);
    endfunction

endpackage

// File: rtl/rxwg_req_sync.sv
module rxwg_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    output logic req_rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], req_async};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign req_rise = chain_q[STAGES-1] & ~last_q;

    // R9: an edge of the synchronized request is a single-cycle event
    a_r9_single_rise: assert property (@(posedge clk) disable iff (rst)
        req_rise |=> !req_rise);

endmodule

// File: rtl/rxwg_seq.sv
module rxwg_seq
    import rxwg_pkg::*;
#(
    parameter word_t FIELD_MASK = 16'h3800,
    parameter word_t FORCE_BITS = 16'h0800
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  pma_done,
    input  logic  port_rdy,
    input  word_t port_rdata,
    output logic  port_en,
    output logic  port_we,
    output word_t port_wdata,
    output logic  rx_reset,
    output logic  seq_done
);
    seq_state_e state_q, state_d;
    logic       guard_q;
    word_t      orig_q;
    word_t      restore_q, restore_d;
    logic       done_q;
    port_ctl_t  ctl;

    always_comb begin
        state_d   = state_q;
        restore_d = restore_q;
        case (state_q)
            S_IDLE:       state_d = S_IDLE;
            S_RD:         state_d = S_WAIT_RD;
            S_WAIT_RD: begin
                if (port_rdy) begin
                    state_d   = S_WR_FORCE;
                    restore_d = guard_q ? orig_q : port_rdata;
                end
            end
            S_WR_FORCE:   state_d = S_WAIT_WR1;
            S_WAIT_WR1:   if (port_rdy) state_d = S_WAIT_PMA;
            S_WAIT_PMA:   if (pma_done) state_d = S_WR_RESTORE;
            S_WR_RESTORE: state_d = S_WAIT_WR2;
            S_WAIT_WR2:   if (port_rdy) state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
        if (start) state_d = S_RD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            restore_q <= '0;
            done_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            restore_q <= restore_d;
            done_q    <= (state_q == S_WAIT_WR2) && port_rdy && !start;
        end
    end

    // Protection flag: set across the force..restore span, cleared on restore completion
    always_ff @(posedge clk) begin
        if (rst)                          guard_q <= 1'b0;
        else if (in_guard_span(state_q))  guard_q <= 1'b1;
        else if (state_q == S_WAIT_WR2)   guard_q <= 1'b0;
    end

    // Saved original, only taken from a read while unprotected
    always_ff @(posedge clk) begin
        if (rst)
            orig_q <= '0;
        else if (state_q == S_WAIT_RD && port_rdy && !guard_q)
            orig_q <= port_rdata;
    end

    always_comb begin
        ctl = ctl_for(state_q);
        unique case (state_q)
            S_WR_FORCE:   port_wdata = merge_field(restore_q, FORCE_BITS, FIELD_MASK);
            S_WR_RESTORE: port_wdata = restore_q;
            default:      port_wdata = '0;
        endcase
    end

    assign port_en  = ctl.en;
    assign port_we  = ctl.we;
    assign rx_reset = ctl.hold_rst;
    assign seq_done = done_q;

    // R5: flag is set after a guarded state
    a_r5_flag_set: assert property (@(posedge clk) disable iff (rst)
        in_guard_span(state_q) |=> guard_q);
    // R5: flag clears after the restore-completion state
    a_r5_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT_WR2) |=> !guard_q);
    // R5: unprotected read is captured as the original
    a_r5_capture: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT_RD && port_rdy && !guard_q) |=> orig_q == $past(port_rdata));
    // R4: protected read keeps the saved original as restore value
    a_r4_keep_orig: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT_RD && port_rdy && guard_q && !start) |=>
            (restore_q == $past(orig_q)) && $stable(orig_q));
    // R6: every read happens with the receiver held in reset
    a_r6_reset_on_read: assert property (@(posedge clk) disable iff (rst)
        (port_en && !port_we) |-> rx_reset);
    // R7: access strobe lasts one cycle
    a_r7_single_en: assert property (@(posedge clk) disable iff (rst)
        (port_en && !start) |=> !port_en);
    // R8: completion is a single pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done);
    // R9: a synchronized edge restarts with the read state
    a_r9_restart: assert property (@(posedge clk) disable iff (rst)
        start |=> (state_q == S_RD));

endmodule

// File: rtl/rx_width_guard.sv
module rx_width_guard
    import rxwg_pkg::*;
#(
    parameter int    ADDR_W      = 9,
    parameter int    SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 9'h011,
    parameter word_t FIELD_MASK  = 16'h3800,
    parameter word_t FORCE_BITS  = 16'h0800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reset_req,
    input  logic              pma_done,
    input  logic              port_rdy,
    input  logic [15:0]       port_rdata,
    output logic [ADDR_W-1:0] port_addr,
    output logic              port_en,
    output logic              port_we,
    output logic [15:0]       port_wdata,
    output logic              rx_reset,
    output logic              seq_done
);
    logic start;

    rxwg_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .req_async (reset_req),
        .req_rise  (start)
    );

    rxwg_seq #(
        .FIELD_MASK (FIELD_MASK),
        .FORCE_BITS (FORCE_BITS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .pma_done   (pma_done),
        .port_rdy   (port_rdy),
        .port_rdata (port_rdata),
        .port_en    (port_en),
        .port_we    (port_we),
        .port_wdata (port_wdata),
        .rx_reset   (rx_reset),
        .seq_done   (seq_done)
    );

    assign port_addr = CFG_ADDR;

endmodule

// File: tb/rx_width_guard_test.sv
module rx_width_guard_test;
    localparam int          ADDR_W  = 9;
    localparam logic [8:0]  CFG     = 9'h011;
    localparam logic [15:0] MASK    = 16'h3800;
    localparam logic [15:0] FBITS   = 16'h0800;
    localparam int          LAT     = 2;
    localparam int          PMA_DLY = 20;
    localparam int          NV      = 6;
    localparam logic [15:0] V_INIT [NV] = '{16'h3C5A, 16'h0000, 16'hFFFF, 16'h2A81, 16'h1801, 16'h07F0};
    // mode 0: plain pass, 1: request at force issue, 2: request in reset-done wait, 3: two interruptions
    localparam int          V_MODE [NV] = '{0, 1, 2, 3, 1, 2};

    logic clk = 0, rst = 1, reset_req = 0, pma_done = 0, port_rdy = 0;
    logic [15:0] port_rdata = '0;
    logic [ADDR_W-1:0] port_addr;
    logic port_en, port_we, rx_reset, seq_done;
    logic [15:0] port_wdata;

    int total = 0, bad = 0;
    logic [15:0] mem = '0;
    logic [15:0] wr_log [8];
    int nwr = 0, nrd = 0, pend = 0, pma_cnt = 0;
    logic pend_we = 0;
    logic [15:0] pend_data = '0;
    int en_dup = 0, en_busy = 0, bad_rd_rst = 0, bad_addr = 0;
    logic en_prev = 0;
    logic finished = 0;

    always #5 clk = ~clk;

    rx_width_guard uut (
        .clk(clk), .rst(rst), .reset_req(reset_req), .pma_done(pma_done),
        .port_rdy(port_rdy), .port_rdata(port_rdata), .port_addr(port_addr),
        .port_en(port_en), .port_we(port_we), .port_wdata(port_wdata),
        .rx_reset(rx_reset), .seq_done(seq_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Register port and reset-done model, acting at falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (port_rdy) port_rdy = 0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    if (pend_we) mem = pend_data;
                    port_rdata = mem;
                    port_rdy = 1;
                end
            end
            if (port_en && en_prev) en_dup++;
            if (port_en) begin
                if (pend > 0) begin
                    en_busy++;
                    if (pend_we) mem = pend_data;
                end
                if (port_addr !== CFG) bad_addr++;
                if (!port_we) begin
                    nrd++;
                    if (!rx_reset) bad_rd_rst++;
                    pma_cnt = 0;
                end else if (nwr < 8) begin
                    wr_log[nwr] = port_wdata;
                    nwr++;
                end else nwr++;
                pend = LAT;
                pend_we = port_we;
                pend_data = port_wdata;
            end
            en_prev = port_en;
            if (rx_reset && pma_cnt < PMA_DLY) pma_cnt++;
            if (!rx_reset) pma_cnt = 0;
            pma_done = (pma_cnt >= PMA_DLY);
        end
    end

    task automatic pulse_req();
        @(negedge clk); reset_req = 1;
        @(negedge clk);
        @(negedge clk); reset_req = 0;
    endtask

    task automatic wait_done(output int seen);
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (seq_done) begin seen = 1; break; end
        end
    endtask

    task automatic clear_log();
        nwr = 0; nrd = 0; en_dup = 0; en_busy = 0; bad_rd_rst = 0; bad_addr = 0;
    endtask

    initial begin
        int seen;
        int interrupts;
        logic [15:0] init;
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 en in reset", port_en, 0);
        check("R10 rx_reset in reset", rx_reset, 0);
        rst = 0;
        @(negedge clk);
        check("R10 idle outputs", {port_en, port_we, rx_reset, seq_done}, 0);

        // R9: synchronizer latency, request driven at a falling edge
        mem = 16'h1234; clear_log();
        reset_req = 1;
        @(negedge clk); check("R9 no early en 1", port_en, 0);
        @(negedge clk); check("R9 no early en 2", port_en, 0);
        @(negedge clk); check("R9 read en at third cycle", {port_en, port_we}, 2'b10);
        reset_req = 0;
        check("R6 rx_reset with read", rx_reset, 1);
        wait_done(seen);
        check("R8 done seen", seen, 1);
        @(negedge clk);
        check("R8 done one cycle", seq_done, 0);
        check("R6 released after pass", rx_reset, 0);
        check("R3 register restored", mem, 16'h1234);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            init = V_INIT[v];
            mem = init; clear_log();
            interrupts = 0;
            fork
                pulse_req();
            join
            if (V_MODE[v] != 0) begin
                while (nwr < 1) @(negedge clk);
                if (V_MODE[v] == 2) begin
                    repeat (6) @(negedge clk);
                    check("R6 held during wait", rx_reset, 1);
                end
                pulse_req(); interrupts++;
                if (V_MODE[v] == 3) begin
                    while (nwr < 2) @(negedge clk);
                    pulse_req(); interrupts++;
                end
            end
            wait_done(seen);
            check("R8 done seen", seen, 1);
            @(negedge clk);
            check("R8 single pulse", seq_done, 0);
            check("R6 idle release", rx_reset, 0);
            check("R4 register holds original", mem, init);
            check("R2 force data", wr_log[0], (init & ~MASK) | (FBITS & MASK));
            check("R1 write count", nwr, 2 + interrupts);
            check("R1 read count", nrd, 1 + interrupts);
            if (nwr >= 1 && nwr <= 8)
                check("R3 restore data", wr_log[nwr-1], init);
            check("R6 rx_reset on reads", bad_rd_rst, 0);
            check("R1 address", bad_addr, 0);
            check("R7 single strobe", en_dup, 0);
            if (interrupts == 0) check("R7 no access while busy", en_busy, 0);
            repeat (4) @(negedge clk);
        end

        // R10: synchronous reset in the middle of a pass
        mem = 16'h5555; clear_log();
        pulse_req();
        while (nwr < 1) @(negedge clk);
        rst = 1;
        @(negedge clk);
        check("R10 mid-pass reset", {port_en, rx_reset, seq_done}, 0);
        rst = 0;
        repeat (5) @(negedge clk);
        check("R10 stays idle", {port_en, rx_reset}, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule